// File: doc/BRIEF.md
# Skew-Tolerant Triple-Replica Line Voter

Three tiles that run the same software in loose lockstep each drive their own copy of a slow serial peripheral interface: an active-low select line plus a small group of data and clock lines. Because the tiles drift against one another by a few clock cycles, their copies cannot be compared directly. This block brings every copy into the system clock domain, stores the samples of each copy in its own small queue from the moment that copy's select goes active, and waits a fixed settling interval. It then pops the queues in step, forms a two-of-three majority on each line separately, and drives one voted select and one voted line group to the real peripheral.

Each voted sample carries a flag per replica that marks any tile whose sample disagreed with the majority, so the faulty tile can be named. A tile that starts too late is flagged late and left out of that transfer. A tile that runs so far ahead that its queue would overflow raises a sticky skew error and is also left out. While no transfer is being voted, the outputs sit at the bus-idle level.

Top module: `skew_voter`

## Requirements
- R1: Each voted line is the bitwise two-of-three majority of the three aligned replica samples; a replica that is left out of the transfer contributes the idle level (`IDLE_LVL`, all zeros by default) in its voting slot.
- R2: Every replica input passes through two synchronising flops. If the second replica to select applies its first sample before clock edge k, the voted select goes low and carries the first voted sample after edge k+HOLD+4; each following sample appears one edge later, and sample j of every replica is voted with sample j of the others.
- R3: A replica that selects up to HOLD cycles after the second one, or up to DEPTH-HOLD-2 cycles before it, is aligned and voted normally.
- R4: A replica that selects more than HOLD cycles after the second one gets its bit of `lateFlag` set before the voted select goes low, is left out of the whole transfer, and the flag stays until the next transfer enters its settling interval.
- R5: With each voted sample, `mismatch` bit r is high for one cycle exactly when replica r takes part in the vote and its sample differs from the voted value on any line; `mismatch` is all zero whenever the voted select is high.
- R6: A replica that selects DEPTH-HOLD-1 or more cycles before the second one overflows its queue; its bit of `skewErr` sets and stays set until reset, and that replica is left out of the vote for the rest of the transfer.
- R7: The voted select returns high and the voted lines return to the idle level on the edge after the last voted sample, once at least two replicas have released their select and emptied their queues; all queues are then cleared.
- R8: After reset, and whenever no transfer is voted, `votedCsN` is 1 and `votedLines` equals the idle level; reset clears `mismatch`, `lateFlag` and `skewErr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock on which all replica lines are sampled |
| rstN | input | 1 | Active-low synchronous reset |
| repCsN | input | 3 | Active-low select of each replica, bit r for replica r |
| repLines | input | 3*W | Line group of each replica, replica r at bits r*W+W-1 down to r*W |
| votedCsN | output | 1 | Voted active-low select to the peripheral |
| votedLines | output | W | Voted line group to the peripheral |
| mismatch | output | 3 | Per-replica disagreement with the current voted sample |
| lateFlag | output | 3 | Per-replica late-start flag for the current or last transfer |
| skewErr | output | 3 | Sticky per-replica queue overflow flag |

## Verification
All results hinge on one reference edge, the edge before which the second replica selects: the voted select and first sample are due HOLD+4 edges later, one sample per edge follows, and the return to idle lands on the edge after the last sample. The bench drives inputs on the falling edge, numbers the rising edges from the start of each scenario, derives that reference edge and the excluded replicas from the offsets it chose, and compares select, lines and mismatch flags on every cycle of the scenario, not only where it expects activity. Late and skew flags are compared once the transfer has closed, and the skew flag again after a later clean transfer and after reset.

// File: rtl/skew_voter_pkg.sv
package skew_voter_pkg;

  localparam int unsigned NREP = 3;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HOLD = 2'd1,
    PH_RUN  = 2'd2
  } phase_e;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic [NREP-1:0] push;
    logic [NREP-1:0] pop;
    logic            load;
    logic            endTxn;
  } strobe_t;

  function automatic logic [1:0] popCount3(input logic [NREP-1:0] v);
    logic [1:0] n;
    n = '0;
    for (int i = 0; i < NREP; i++) n = n + {1'b0, v[i]};
    return n;
  endfunction

endpackage

// File: rtl/sv_lane.sv
module sv_lane #(
  parameter int unsigned W = 3,
  parameter int unsigned DEPTH = 8,
  parameter logic [W-1:0] IDLE_LVL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         csNIn,
  input  logic [W-1:0] linesIn,
  input  logic         push,
  input  logic         pop,
  input  logic         flush,
  output logic         activeSync,
  output logic [W-1:0] headData,
  output logic         nonEmpty,
  output logic         full
);

  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic         csS1, csS2;
  logic [W-1:0] linS1, linS2;
  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] rdPtr, wrPtr;
  logic [CW-1:0] count;
  logic doPush, doPop;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // Two-flop synchroniser on select and lines
  always_ff @(posedge clk) begin
    if (!rstN) begin
      csS1  <= 1'b1;
      csS2  <= 1'b1;
      linS1 <= IDLE_LVL;
      linS2 <= IDLE_LVL;
    end else begin
      csS1  <= csNIn;
      csS2  <= csS1;
      linS1 <= linesIn;
      linS2 <= linS1;
    end
  end

  assign activeSync = ~csS2;
  assign nonEmpty   = (count != '0);
  assign full       = (count == CW'(DEPTH));
  assign doPop      = pop & nonEmpty;
  assign doPush     = push & (~full | doPop);
  assign headData   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      if (doPush && !doPop)      count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (doPush && !flush) mem[wrPtr] <= linS2;
  end

endmodule

// File: rtl/sv_datapath.sv
module sv_datapath
  import skew_voter_pkg::*;
#(
  parameter int unsigned W = 3,
  parameter int unsigned DEPTH = 8,
  parameter logic [W-1:0] IDLE_LVL = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NREP-1:0]   repCsN,
  input  logic [NREP*W-1:0] repLines,
  input  strobe_t           stb,
  output logic [NREP-1:0]   activeSync,
  output logic [NREP-1:0]   nonEmpty,
  output logic [NREP-1:0]   full,
  output logic              votedCsN,
  output logic [W-1:0]      votedLines,
  output logic [NREP-1:0]   mismatch
);

  logic [W-1:0]    head [NREP];
  logic [W-1:0]    slot [NREP];
  logic [W-1:0]    voted;
  logic [NREP-1:0] misNext;

  for (genvar r = 0; r < NREP; r++) begin : g_lane
    sv_lane #(.W(W), .DEPTH(DEPTH), .IDLE_LVL(IDLE_LVL)) u_lane (
      .clk        (clk),
      .rstN       (rstN),
      .csNIn      (repCsN[r]),
      .linesIn    (repLines[r*W +: W]),
      .push       (stb.push[r]),
      .pop        (stb.pop[r]),
      .flush      (stb.endTxn),
      .activeSync (activeSync[r]),
      .headData   (head[r]),
      .nonEmpty   (nonEmpty[r]),
      .full       (full[r])
    );
  end

  // A replica not popped this cycle votes with the idle level
  always_comb begin
    for (int r = 0; r < NREP; r++) slot[r] = stb.pop[r] ? head[r] : IDLE_LVL;
    voted = (slot[0] & slot[1]) | (slot[0] & slot[2]) | (slot[1] & slot[2]);
    for (int r = 0; r < NREP; r++) misNext[r] = stb.pop[r] && (slot[r] != voted);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      votedCsN   <= 1'b1;
      votedLines <= IDLE_LVL;
      mismatch   <= '0;
    end else if (stb.endTxn) begin
      votedCsN   <= 1'b1;
      votedLines <= IDLE_LVL;
      mismatch   <= '0;
    end else if (stb.load) begin
      votedCsN   <= 1'b0;
      votedLines <= voted;
      mismatch   <= misNext;
    end else begin
      mismatch   <= '0;
    end
  end

endmodule

// File: rtl/sv_ctrl.sv
module sv_ctrl
  import skew_voter_pkg::*;
#(
  parameter int unsigned HOLD = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NREP-1:0] activeSync,
  input  logic [NREP-1:0] nonEmpty,
  input  logic [NREP-1:0] full,
  output strobe_t         stb,
  output logic [NREP-1:0] lateFlag,
  output logic [NREP-1:0] skewErr
);

  localparam int unsigned HCW = (HOLD > 1) ? $clog2(HOLD + 1) : 1;

  phase_e          phase;
  logic [HCW-1:0]  holdCnt;
  logic [NREP-1:0] started, ended, excluded;
  logic [NREP-1:0] live, ovf, doneVec;
  logic            enterRun;

  always_comb begin
    live       = ~excluded;
    stb.push   = activeSync & live & ~ended;
    stb.pop    = (phase == PH_RUN) ? (nonEmpty & live) : '0;
    stb.load   = |stb.pop;
    doneVec    = ended & (~nonEmpty | excluded);
    stb.endTxn = (phase == PH_RUN) && (popCount3(doneVec) >= 2'd2);
    ovf        = stb.push & full & ~stb.pop;
    enterRun   = (phase == PH_HOLD) && (holdCnt == HCW'(HOLD - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      holdCnt  <= '0;
      started  <= '0;
      ended    <= '0;
      excluded <= '0;
      lateFlag <= '0;
      skewErr  <= '0;
    end else begin
      skewErr <= skewErr | ovf;
      if (stb.endTxn) begin
        phase    <= PH_IDLE;
        holdCnt  <= '0;
        started  <= '0;
        ended    <= '0;
        excluded <= '0;
      end else begin
        started  <= started | activeSync;
        ended    <= ended | (started & ~activeSync);
        excluded <= excluded | ovf | (enterRun ? ~started : '0);
        unique case (phase)
          PH_IDLE: begin
            if (popCount3(nonEmpty & live) >= 2'd2) begin
              phase    <= PH_HOLD;
              holdCnt  <= '0;
              lateFlag <= '0;
            end
          end
          PH_HOLD: begin
            if (enterRun) begin
              phase    <= PH_RUN;
              lateFlag <= ~started & live;
            end else begin
              holdCnt <= holdCnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/skew_voter.sv
module skew_voter
  import skew_voter_pkg::*;
#(
  parameter int unsigned W = 3,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned HOLD = 3,
  parameter logic [W-1:0] IDLE_LVL = '0
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [2:0]     repCsN,
  input  logic [3*W-1:0] repLines,
  output logic           votedCsN,
  output logic [W-1:0]   votedLines,
  output logic [2:0]     mismatch,
  output logic [2:0]     lateFlag,
  output logic [2:0]     skewErr
);

  strobe_t         stb;
  logic [NREP-1:0] activeSync, nonEmpty, full;

  sv_ctrl #(.HOLD(HOLD)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .activeSync (activeSync),
    .nonEmpty   (nonEmpty),
    .full       (full),
    .stb        (stb),
    .lateFlag   (lateFlag),
    .skewErr    (skewErr)
  );

  sv_datapath #(.W(W), .DEPTH(DEPTH), .IDLE_LVL(IDLE_LVL)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .repCsN     (repCsN),
    .repLines   (repLines),
    .stb        (stb),
    .activeSync (activeSync),
    .nonEmpty   (nonEmpty),
    .full       (full),
    .votedCsN   (votedCsN),
    .votedLines (votedLines),
    .mismatch   (mismatch)
  );

endmodule

// File: rtl/skew_voter_checker.sv
module skew_voter_checker #(
  parameter int unsigned W = 3,
  parameter logic [W-1:0] IDLE_LVL = '0
) (
  input logic         clk,
  input logic         rstN,
  input logic         votedCsN,
  input logic [W-1:0] votedLines,
  input logic [2:0]   mismatch,
  input logic [2:0]   lateFlag,
  input logic [2:0]   skewErr
);

  // R8: released select always carries the idle line level
  p_idle_level_r8: assert property (@(posedge clk) disable iff (!rstN)
    votedCsN |-> (votedLines == IDLE_LVL));

  // R5: no disagreement reported outside a voted sample
  p_quiet_mismatch_r5: assert property (@(posedge clk) disable iff (!rstN)
    votedCsN |-> (mismatch == 3'b000));

  // R6: skew error bits never clear once set
  p_skew_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (skewErr != 3'b000) |=> ((skewErr & $past(skewErr)) == $past(skewErr)));

  // R4: a late flag is raised before the first voted sample is driven
  p_late_before_data_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(|lateFlag) |-> votedCsN);

endmodule

bind skew_voter skew_voter_checker #(.W(W), .IDLE_LVL(IDLE_LVL)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .votedCsN   (votedCsN),
  .votedLines (votedLines),
  .mismatch   (mismatch),
  .lateFlag   (lateFlag),
  .skewErr    (skewErr)
);

// File: tb/skew_voter_bench.sv
module skew_voter_bench;

  localparam int W = 3;
  localparam int DEPTH = 8;
  localparam int HOLD = 3;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [2:0]     repCsN = 3'b111;
  logic [3*W-1:0] repLines = '0;
  logic           votedCsN;
  logic [W-1:0]   votedLines;
  logic [2:0]     mismatch, lateFlag, skewErr;

  int  nChecks = 0;
  int  nFail = 0;
  bit  doneFlag = 1'b0;
  logic [2:0] skewAcc = 3'b000;

  always #4 clk = ~clk;

  skew_voter #(.W(W), .DEPTH(DEPTH), .HOLD(HOLD), .IDLE_LVL('0)) u_skew_voter (
    .clk(clk), .rstN(rstN), .repCsN(repCsN), .repLines(repLines),
    .votedCsN(votedCsN), .votedLines(votedLines), .mismatch(mismatch),
    .lateFlag(lateFlag), .skewErr(skewErr)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] baseVal(input int seed, input int j);
    return 3'((j * 5 + seed * 3 + (j >> 1)) & 7);
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; repCsN = 3'b111; repLines = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R8", "reset votedCsN", int'(votedCsN), 1);
    check("R8", "reset votedLines", int'(votedLines), 0);
    check("R8", "reset mismatch", int'(mismatch), 0);
    check("R8", "reset lateFlag", int'(lateFlag), 0);
    check("R8", "reset skewErr", int'(skewErr), 0);
    skewAcc = 3'b000;
  endtask

  // One transfer: replica r starts 'off[r]' edges into the scenario and
  // sends len samples; flip masks corrupt sample 2 of each replica.
  task automatic runTxn(input string tag, input int o0, input int o1, input int o2,
                        input int len, input int seed,
                        input logic [2:0] f0, input logic [2:0] f1, input logic [2:0] f2);
    int off [3];
    logic [2:0] flip [3];
    logic [2:0] dat [3][16];
    logic [2:0] excl, lateExp;
    int k, lo, hi, first, tEnd;
    off[0] = o0; off[1] = o1; off[2] = o2;
    flip[0] = f0; flip[1] = f1; flip[2] = f2;
    lo = o0; hi = o0;
    for (int r = 1; r < 3; r++) begin
      if (off[r] < lo) lo = off[r];
      if (off[r] > hi) hi = off[r];
    end
    k = o0 + o1 + o2 - lo - hi;
    first = k + HOLD + 4;
    for (int r = 0; r < 3; r++) begin
      lateExp[r] = (off[r] > k + HOLD);
      excl[r] = lateExp[r] || ((k - off[r]) >= (DEPTH - HOLD - 1));
      if ((k - off[r]) >= (DEPTH - HOLD - 1)) skewAcc[r] = 1'b1;
      for (int j = 0; j < 16; j++) dat[r][j] = baseVal(seed, j) ^ ((j == 2) ? flip[r] : 3'b000);
    end
    tEnd = first + len + 3;
    if (hi + len + 4 > tEnd) tEnd = hi + len + 4;
    for (int t = 0; t <= tEnd; t++) begin
      @(negedge clk);
      if (t > 0) begin
        int e;
        logic expCs;
        logic [2:0] slot [3];
        logic [2:0] v, expMis;
        e = t - 1;
        expCs = !(e >= first && e < first + len);
        v = 3'b000; expMis = 3'b000;
        if (!expCs) begin
          for (int r = 0; r < 3; r++) slot[r] = excl[r] ? 3'b000 : dat[r][e - first];
          v = (slot[0] & slot[1]) | (slot[0] & slot[2]) | (slot[1] & slot[2]);
          for (int r = 0; r < 3; r++) expMis[r] = !excl[r] && (slot[r] != v);
        end
        // R2 and R7 timing of the voted select, R1 value, R5 flags
        check("R2/R7", {tag, " votedCsN"}, int'(votedCsN), int'(expCs));
        check("R1", {tag, " votedLines"}, int'(votedLines), int'(v));
        check("R5", {tag, " mismatch"}, int'(mismatch), int'(expMis));
      end
      for (int r = 0; r < 3; r++) begin
        if (t >= off[r] && t < off[r] + len) begin
          repCsN[r] = 1'b0;
          repLines[r*W +: W] = dat[r][t - off[r]];
        end else begin
          repCsN[r] = 1'b1;
          repLines[r*W +: W] = '0;
        end
      end
    end
    repeat (3) @(negedge clk);
    check("R4", {tag, " lateFlag"}, int'(lateFlag), int'(lateExp));
    check("R6", {tag, " skewErr"}, int'(skewErr), int'(skewAcc));
  endtask

  task automatic scenAligned();
    runTxn("R1 aligned", 0, 0, 0, 6, 1, 3'b000, 3'b000, 3'b000);
  endtask

  task automatic scenSkewWithin();
    // R3: replica 2 trails the second by HOLD, replica 1 leads by one
    runTxn("R3 skew edge", 1, 0, 4, 7, 2, 3'b000, 3'b000, 3'b101);
  endtask

  task automatic scenLeadLimit();
    // R3: lead of DEPTH-HOLD-2 still aligned, R5 single flipped replica
    runTxn("R3 lead limit", 0, 3, 3, 6, 3, 3'b000, 3'b110, 3'b000);
  endtask

  task automatic scenLate();
    // R4: replica 2 arrives HOLD+1 after the second
    runTxn("R4 late", 0, 1, 5, 6, 4, 3'b011, 3'b100, 3'b000);
  endtask

  task automatic scenOverflow();
    // R6: replica 0 leads by DEPTH-HOLD-1 and overflows
    runTxn("R6 overflow", 0, 4, 4, 10, 5, 3'b000, 3'b011, 3'b000);
  endtask

  task automatic scenStickyThenReset();
    runTxn("R6 sticky", 0, 0, 0, 5, 6, 3'b000, 3'b000, 3'b010);
    doReset();
    check("R8", "skewErr cleared by reset", int'(skewErr), 0);
  endtask

  initial begin
    doReset();
    scenAligned();
    scenSkewWithin();
    scenLeadLimit();
    scenLate();
    scenOverflow();
    scenStickyThenReset();
    scenAligned();
    if (!doneFlag) begin
      doneFlag = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!doneFlag) begin
      doneFlag = 1'b1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

endmodule